// File: doc/BRIEF.md
# Dual-Clock Word FIFO with Selectable Flow Timing

This block carries 36-bit words from a producer on one clock to a consumer on another. The two clocks run freely and may be unrelated or the very same net. Storage is an on-block two-port array. The write pointer and the read pointer each cross to the other side as Gray code through two flip-flop stages. Every flag is therefore computed from local registers, and any flag that is stale errs on the safe side.

The flow style is fixed while reset is held. In standard style the consumer sees an empty indication, pulses a read enable and finds the word on the output after that clock edge. In fall-through style the oldest word moves to the output register without any request. A valid indication marks it, and a read enable consumes it. The producer sees a full indication in standard style and a ready indication in fall-through style. Each side also has a near-limit flag whose threshold is either captured from input pins during reset or left at a built-in default.

Top module: `dcfifo_top`

## Requirements
- R1: While reset is low and after its release, the read pointer and the write pointer are zero and `rd_data` is zero. `rd_almost_empty` is 1 and `wr_almost_full` is 0. With `mode_sel`=0, `rd_flag` is 1 (empty) and `wr_flag` is 0 (not full). With `mode_sel`=1, `rd_flag` is 0 (no valid word) and `wr_flag` is 1 (ready).
- R2: Words leave in the order they were written, with all 36 bits intact, including all-zero and all-one words.
- R3: With `mode_sel`=0, no word reaches `rd_data` until `rd_en` is sampled high while `rd_flag` is 0. The word is then on `rd_data` after that same rising edge of `rd_clk`.
- R4: With `mode_sel`=1, the oldest stored word is placed on `rd_data` with `rd_flag`=1 without any `rd_en`. It stays there until `rd_en` is sampled high, and that edge consumes it.
- R5: Capacity is DEPTH words with `mode_sel`=0 and DEPTH+1 words with `mode_sel`=1, because the output register holds one word. At capacity `wr_flag` shows full (1 in standard style, 0 in fall-through style), and a write attempted then stores nothing.
- R6: A read attempted while no word is available leaves `rd_data` unchanged and does not move the read pointer. The next word written is the next word read.
- R7: `rd_almost_empty` is 1 exactly when the number of words the read side holds is at or below the empty threshold. In fall-through style that number includes the word in the output register.
- R8: `wr_almost_full` is 1 exactly when the free space seen by the write side is at or below the full threshold.
- R9: When `ofs_load`=1 during reset, the thresholds are taken from `af_offset` and `ae_offset`. Otherwise both thresholds are 8.
- R10: When both clocks are the same, a write and a read on the same edge both complete, and no word is lost or repeated.
- R11: With unrelated clocks, every pointer update crossing the boundary changes at most one Gray bit. A side never reports a word or a free slot before it exists.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Producer clock |
| wr_rst_n | input | 1 | Producer-side synchronous active-low reset |
| wr_en | input | 1 | Write request |
| wr_data | input | DATA_W | Word to store |
| wr_flag | output | 1 | Full (standard style) or ready (fall-through style) |
| wr_almost_full | output | 1 | Free space at or below the full threshold |
| rd_clk | input | 1 | Consumer clock |
| rd_rst_n | input | 1 | Consumer-side synchronous active-low reset |
| rd_en | input | 1 | Read request or consume |
| rd_data | output | DATA_W | Output word register |
| rd_flag | output | 1 | Empty (standard style) or valid (fall-through style) |
| rd_almost_empty | output | 1 | Held words at or below the empty threshold |
| mode_sel | input | 1 | 0 standard, 1 fall-through; sampled during reset |
| ofs_load | input | 1 | 1 during reset loads thresholds from pins |
| af_offset | input | AW+1 | Full threshold value to load |
| ae_offset | input | AW+1 | Empty threshold value to load |

## Verification
The bench fills the queue to its limit in both styles. A design that ignored the output register in fall-through style would accept one word too few or one too many, and a design that wrote while full would give back an extra word during the drain. Reads are issued against an empty queue, where a design that moved its pointer would return stale data or skip the next word. The bench streams writes and reads on the same edge, which exposes lost or doubled words. A run with unrelated clocks shows whether a flag clears before the crossing pointer has settled, because the consumer would then read unwritten data. Both thresholds are probed one word either side of their edge.

// File: rtl/dcfifo_pkg.sv
// Shared definitions for the dual-clock FIFO.
// Assumes nothing beyond a synthesizable enum.
package dcfifo_pkg;
    // Flow style captured during reset
    typedef enum logic {
        FLOW_STD  = 1'b0,
        FLOW_FWFT = 1'b1
    } flow_mode_e;
endpackage

// File: rtl/dcfifo_sync.sv
// Two-stage synchronizer for a Gray-coded pointer bus.
// Assumes the input changes at most one bit per source clock.
module dcfifo_sync #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    // Capture then settle the foreign pointer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/dcfifo_ram.sv
// Two-port storage array: write on one clock, registered read on the other.
// Assumes the controllers never write and read the same live slot unsafely.
module dcfifo_ram #(
    parameter  int DW    = 36,
    parameter  int DEPTH = 2048,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic          wr_clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          rd_clk,
    input  logic          rd_rst_n,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem [DEPTH];

    // Store an accepted word
    always_ff @(posedge wr_clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Load the output register on a fetch
    always_ff @(posedge rd_clk) begin
        if (!rd_rst_n)  rdata <= '0;
        else if (re)    rdata <= mem[raddr];
    end
endmodule

// File: rtl/dcfifo_wr_ctl.sv
// Write-side controller: write pointer, full or ready flag, near-full flag.
// Assumes rgray_s is the read pointer already synchronized to this clock.
module dcfifo_wr_ctl #(
    parameter  int DEPTH   = 2048,
    parameter  int DEF_OFS = 8,
    localparam int AW      = $clog2(DEPTH),
    localparam int PW      = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mode_sel,
    input  logic          ofs_load,
    input  logic [PW-1:0] af_ofs,
    input  logic          wr_en,
    input  logic [PW-1:0] rgray_s,
    output logic          ram_we,
    output logic [AW-1:0] ram_waddr,
    output logic [PW-1:0] wgray,
    output logic          wr_flag,
    output logic          almost_full
);
    import dcfifo_pkg::*;

    flow_mode_e    mode_q;
    logic [PW-1:0] af_q;
    logic [PW-1:0] wptr;
    logic [PW-1:0] wptr_nxt;
    logic [PW-1:0] rptr_b;
    logic [PW-1:0] used;
    logic [PW-1:0] space;
    logic          full_int;

    // Gray to binary for the synchronized read pointer
    for (genvar i = 0; i < PW; i++) begin : g_g2b
        assign rptr_b[i] = ^rgray_s[PW-1:i];
    end

    // Occupancy, space and flags from local registers
    always_comb begin
        used        = wptr - rptr_b;
        space       = PW'(DEPTH) - used;
        full_int    = (used == PW'(DEPTH));
        ram_we      = wr_en && !full_int;
        wptr_nxt    = wptr + PW'(1);
        ram_waddr   = wptr[AW-1:0];
        almost_full = (space <= af_q);
        wr_flag     = (mode_q == FLOW_FWFT) ? !full_int : full_int;
    end

    // Pointer advance and reset-time configuration capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr   <= '0;
            wgray  <= '0;
            mode_q <= flow_mode_e'(mode_sel);
            af_q   <= ofs_load ? af_ofs : PW'(DEF_OFS);
        end else if (ram_we) begin
            wptr  <= wptr_nxt;
            wgray <= wptr_nxt ^ (wptr_nxt >> 1);
        end
    end

    // R5: a write at capacity leaves the pointer alone
    a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (full_int && wr_en) |=> $stable(wptr));
    // R5: occupancy never exceeds the array
    a_r5_used_bound: assert property (@(posedge clk) disable iff (!rst_n)
        used <= PW'(DEPTH));
    // R11: the outgoing Gray pointer moves one bit at a time
    a_r11_wgray_step: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(wgray ^ $past(wgray)) <= 1);
endmodule

// File: rtl/dcfifo_rd_ctl.sv
// Read-side controller: read pointer, fetch control, empty or valid flag,
// near-empty flag. Assumes wgray_s is the synchronized write pointer.
module dcfifo_rd_ctl #(
    parameter  int DEPTH   = 2048,
    parameter  int DEF_OFS = 8,
    localparam int AW      = $clog2(DEPTH),
    localparam int PW      = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mode_sel,
    input  logic          ofs_load,
    input  logic [PW-1:0] ae_ofs,
    input  logic          rd_en,
    input  logic [PW-1:0] wgray_s,
    output logic          ram_re,
    output logic [AW-1:0] ram_raddr,
    output logic [PW-1:0] rgray,
    output logic          rd_flag,
    output logic          almost_empty
);
    import dcfifo_pkg::*;

    flow_mode_e    mode_q;
    logic [PW-1:0] ae_q;
    logic [PW-1:0] rptr;
    logic [PW-1:0] rptr_nxt;
    logic [PW-1:0] wptr_b;
    logic [PW-1:0] avail;
    logic [PW-1:0] level;
    logic          ram_empty;
    logic          ovalid;
    logic          fwft;

    // Gray to binary for the synchronized write pointer
    for (genvar i = 0; i < PW; i++) begin : g_g2b
        assign wptr_b[i] = ^wgray_s[PW-1:i];
    end

    // Availability, fetch decision and flags
    always_comb begin
        fwft         = (mode_q == FLOW_FWFT);
        avail        = wptr_b - rptr;
        ram_empty    = (avail == '0);
        ram_re       = fwft ? (!ram_empty && (!ovalid || rd_en))
                            : (rd_en && !ram_empty);
        rptr_nxt     = rptr + PW'(1);
        ram_raddr    = rptr[AW-1:0];
        level        = avail + ((fwft && ovalid) ? PW'(1) : PW'(0));
        almost_empty = (level <= ae_q);
        rd_flag      = fwft ? ovalid : ram_empty;
    end

    // Pointer advance, output-valid tracking and configuration capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rptr   <= '0;
            rgray  <= '0;
            ovalid <= 1'b0;
            mode_q <= flow_mode_e'(mode_sel);
            ae_q   <= ofs_load ? ae_ofs : PW'(DEF_OFS);
        end else begin
            if (ram_re) begin
                rptr  <= rptr_nxt;
                rgray <= rptr_nxt ^ (rptr_nxt >> 1);
            end
            if (fwft) begin
                if (ram_re)     ovalid <= 1'b1;
                else if (rd_en) ovalid <= 1'b0;
            end
        end
    end

    // R6: a standard read with nothing stored does not move the pointer
    a_r6_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        (!fwft && ram_empty && rd_en) |=> $stable(rptr));
    // R3: standard style fetches only on request
    a_r3_no_prefetch: assert property (@(posedge clk) disable iff (!rst_n)
        (!fwft && !rd_en) |=> $stable(rptr));
    // R4: a presented word stays valid until consumed
    a_r4_hold_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (fwft && ovalid && !rd_en) |=> ovalid);
    // R11: the outgoing Gray pointer moves one bit at a time
    a_r11_rgray_step: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(rgray ^ $past(rgray)) <= 1);
    // R5: the read side never sees more than the array holds
    a_r5_avail_bound: assert property (@(posedge clk) disable iff (!rst_n)
        avail <= PW'(DEPTH));
endmodule

// File: rtl/dcfifo_top.sv
// Dual-clock FIFO top: array, two controllers, two pointer synchronizers.
// Assumes DEPTH is a power of two; mode_sel and ofs_load are steady in reset.
module dcfifo_top #(
    parameter  int DATA_W  = 36,
    parameter  int DEPTH   = 2048,
    parameter  int DEF_OFS = 8,
    localparam int AW      = $clog2(DEPTH),
    localparam int PW      = AW + 1
) (
    input  logic              wr_clk,
    input  logic              wr_rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_flag,
    output logic              wr_almost_full,
    input  logic              rd_clk,
    input  logic              rd_rst_n,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_flag,
    output logic              rd_almost_empty,
    input  logic              mode_sel,
    input  logic              ofs_load,
    input  logic [PW-1:0]     af_offset,
    input  logic [PW-1:0]     ae_offset
);
    logic          ram_we;
    logic          ram_re;
    logic [AW-1:0] ram_waddr;
    logic [AW-1:0] ram_raddr;
    logic [PW-1:0] wgray;
    logic [PW-1:0] rgray;
    logic [PW-1:0] wgray_s;
    logic [PW-1:0] rgray_s;

    dcfifo_ram #(.DW(DATA_W), .DEPTH(DEPTH)) u_ram (
        .wr_clk   (wr_clk),
        .we       (ram_we),
        .waddr    (ram_waddr),
        .wdata    (wr_data),
        .rd_clk   (rd_clk),
        .rd_rst_n (rd_rst_n),
        .re       (ram_re),
        .raddr    (ram_raddr),
        .rdata    (rd_data)
    );

    dcfifo_wr_ctl #(.DEPTH(DEPTH), .DEF_OFS(DEF_OFS)) u_wr (
        .clk         (wr_clk),
        .rst_n       (wr_rst_n),
        .mode_sel    (mode_sel),
        .ofs_load    (ofs_load),
        .af_ofs      (af_offset),
        .wr_en       (wr_en),
        .rgray_s     (rgray_s),
        .ram_we      (ram_we),
        .ram_waddr   (ram_waddr),
        .wgray       (wgray),
        .wr_flag     (wr_flag),
        .almost_full (wr_almost_full)
    );

    dcfifo_rd_ctl #(.DEPTH(DEPTH), .DEF_OFS(DEF_OFS)) u_rd (
        .clk          (rd_clk),
        .rst_n        (rd_rst_n),
        .mode_sel     (mode_sel),
        .ofs_load     (ofs_load),
        .ae_ofs       (ae_offset),
        .rd_en        (rd_en),
        .wgray_s      (wgray_s),
        .ram_re       (ram_re),
        .ram_raddr    (ram_raddr),
        .rgray        (rgray),
        .rd_flag      (rd_flag),
        .almost_empty (rd_almost_empty)
    );

    dcfifo_sync #(.W(PW)) u_w2r (
        .clk   (rd_clk),
        .rst_n (rd_rst_n),
        .d     (wgray),
        .q     (wgray_s)
    );

    dcfifo_sync #(.W(PW)) u_r2w (
        .clk   (wr_clk),
        .rst_n (wr_rst_n),
        .d     (rgray),
        .q     (rgray_s)
    );
endmodule

// File: tb/dcfifo_top_tb_top.sv
// Directed bench for the dual-clock FIFO; one task per scenario.
module dcfifo_top_tb_top;
    localparam int DW    = 36;
    localparam int DEPTH = 64;
    localparam int PW    = 7;

    logic clk_a = 1'b0;
    logic clk_b = 1'b0;
    logic async_sel = 1'b0;
    logic rd_clk;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic rd_en = 1'b0;
    logic mode_sel = 1'b0;
    logic ofs_load = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic [PW-1:0] af_ofs = '0;
    logic [PW-1:0] ae_ofs = '0;
    logic [DW-1:0] rd_data;
    logic wr_flag, wr_af, rd_flag, rd_ae;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk_a = ~clk_a;
    always #5 clk_b = ~clk_b;
    assign rd_clk = async_sel ? clk_b : clk_a;

    dcfifo_top #(.DATA_W(DW), .DEPTH(DEPTH), .DEF_OFS(8)) dut_i (
        .wr_clk(clk_a), .wr_rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .wr_flag(wr_flag), .wr_almost_full(wr_af),
        .rd_clk(rd_clk), .rd_rst_n(rst_n), .rd_en(rd_en), .rd_data(rd_data),
        .rd_flag(rd_flag), .rd_almost_empty(rd_ae),
        .mode_sel(mode_sel), .ofs_load(ofs_load),
        .af_offset(af_ofs), .ae_offset(ae_ofs)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] word(input int base, input int i);
        return {base[7:0], 8'h5A, i[19:0]};
    endfunction

    function automatic bit wr_ok();
        return mode_sel ? wr_flag : !wr_flag;
    endfunction

    function automatic bit rd_has();
        return mode_sel ? rd_flag : !rd_flag;
    endfunction

    task automatic do_reset(input bit mode, input bit load, input int af, input int ae, input bit asy);
        @(negedge clk_a);
        rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
        async_sel = asy; mode_sel = mode; ofs_load = load;
        af_ofs = af[PW-1:0]; ae_ofs = ae[PW-1:0];
        repeat (8) @(negedge clk_a);
        rst_n = 1'b1;
        repeat (3) @(negedge clk_a);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk_a);
    endtask

    task automatic push(input logic [DW-1:0] d);
        @(negedge clk_a);
        while (!wr_ok()) @(negedge clk_a);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk_a);
        wr_en = 1'b0;
    endtask

    task automatic pop(output logic [DW-1:0] d);
        @(negedge rd_clk);
        while (!rd_has()) @(negedge rd_clk);
        if (mode_sel) begin
            d = rd_data;
            rd_en = 1'b1;
            @(negedge rd_clk);
            rd_en = 1'b0;
        end else begin
            rd_en = 1'b1;
            @(negedge rd_clk);
            rd_en = 1'b0;
            d = rd_data;
        end
    endtask

    task automatic t_reset_state();
        do_reset(1'b0, 1'b0, 0, 0, 1'b0);
        chk("R1 std empty", rd_flag, 1);
        chk("R1 std full", wr_flag, 0);
        chk("R1 almost_empty", rd_ae, 1);
        chk("R1 almost_full", wr_af, 0);
        chk("R1 data", rd_data, 0);
        do_reset(1'b1, 1'b0, 0, 0, 1'b0);
        chk("R1 fwft valid", rd_flag, 0);
        chk("R1 fwft ready", wr_flag, 1);
    endtask

    task automatic t_std_order();
        logic [DW-1:0] v [7];
        logic [DW-1:0] d;
        do_reset(1'b0, 1'b0, 0, 0, 1'b0);
        for (int i = 0; i < 5; i++) v[i] = word(1, i);
        v[5] = '1;
        v[6] = '0;
        for (int i = 0; i < 7; i++) push(v[i]);
        idle(6);
        chk("R3 not empty", rd_flag, 0);
        chk("R3 no word without read", rd_data, 0);
        for (int i = 0; i < 7; i++) begin
            pop(d);
            chk("R2 order", d, v[i]);
        end
        idle(4);
        chk("R3 empty after drain", rd_flag, 1);
    endtask

    task automatic t_empty_read();
        logic [DW-1:0] last;
        logic [DW-1:0] d;
        last = rd_data;
        @(negedge clk_a);
        rd_en = 1'b1;
        repeat (3) @(negedge clk_a);
        rd_en = 1'b0;
        chk("R6 data held on empty read", rd_data, last);
        push(word(2, 0));
        pop(d);
        chk("R6 next word after empty read", d, word(2, 0));
    endtask

    task automatic t_fwft();
        logic [DW-1:0] d;
        do_reset(1'b1, 1'b0, 0, 0, 1'b0);
        push(word(3, 0));
        for (int k = 0; k < 10; k++) if (!rd_flag) @(negedge clk_a);
        chk("R4 valid without request", rd_flag, 1);
        chk("R4 word presented", rd_data, word(3, 0));
        idle(3);
        chk("R4 word held", rd_data, word(3, 0));
        push(word(3, 1));
        push(word(3, 2));
        for (int i = 0; i < 3; i++) begin
            pop(d);
            chk("R4 fwft order", d, word(3, i));
        end
        idle(4);
        chk("R4 not valid when drained", rd_flag, 0);
        @(negedge clk_a);
        rd_en = 1'b1;
        repeat (3) @(negedge clk_a);
        rd_en = 1'b0;
        push(word(3, 9));
        pop(d);
        chk("R6 fwft next word after empty read", d, word(3, 9));
    endtask

    task automatic t_full_std();
        logic [DW-1:0] d;
        do_reset(1'b0, 1'b0, 0, 0, 1'b0);
        for (int i = 0; i < DEPTH - 9; i++) push(word(4, i));
        idle(2);
        chk("R9 default full threshold, space 9", wr_af, 0);
        push(word(4, DEPTH - 9));
        idle(1);
        chk("R9 default full threshold, space 8", wr_af, 1);
        for (int i = DEPTH - 8; i < DEPTH; i++) push(word(4, i));
        idle(2);
        chk("R5 std full", wr_flag, 1);
        @(negedge clk_a);
        wr_en = 1'b1; wr_data = 36'hDEAD;
        @(negedge clk_a);
        wr_en = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            pop(d);
            chk("R5 std drain", d, word(4, i));
        end
        idle(6);
        chk("R5 extra write dropped", rd_flag, 1);
    endtask

    task automatic t_full_fwft();
        logic [DW-1:0] d;
        int accepted;
        accepted = 0;
        do_reset(1'b1, 1'b0, 0, 0, 1'b0);
        for (int k = 0; k < DEPTH + 20; k++) begin
            @(negedge clk_a);
            if (wr_ok()) begin
                wr_en = 1'b1; wr_data = word(5, accepted);
                accepted++;
                @(negedge clk_a);
                wr_en = 1'b0;
            end
        end
        chk("R5 fwft capacity", accepted, DEPTH + 1);
        chk("R5 fwft not ready", wr_flag, 0);
        @(negedge clk_a);
        wr_en = 1'b1; wr_data = 36'hBEEF;
        @(negedge clk_a);
        wr_en = 1'b0;
        for (int i = 0; i < DEPTH + 1; i++) begin
            pop(d);
            chk("R5 fwft drain", d, word(5, i));
        end
        idle(6);
        chk("R5 fwft extra write dropped", rd_flag, 0);
    endtask

    task automatic t_offsets();
        logic [DW-1:0] d;
        do_reset(1'b0, 1'b1, 5, 3, 1'b0);
        for (int i = 0; i < 3; i++) push(word(6, i));
        idle(5);
        chk("R7 almost_empty at threshold", rd_ae, 1);
        push(word(6, 3));
        idle(5);
        chk("R7 almost_empty above threshold", rd_ae, 0);
        pop(d);
        chk("R7 data", d, word(6, 0));
        chk("R7 almost_empty after read", rd_ae, 1);
        for (int i = 0; i < DEPTH - 9; i++) push(word(6, 4 + i));
        idle(5);
        chk("R8 almost_full space 6", wr_af, 0);
        push(word(6, 99));
        idle(1);
        chk("R8 almost_full space 5", wr_af, 1);
    endtask

    task automatic t_same_edge();
        logic [DW-1:0] q [$];
        logic [DW-1:0] d;
        logic [DW-1:0] e;
        bit take;
        do_reset(1'b0, 1'b0, 0, 0, 1'b0);
        push(word(7, 0));
        push(word(7, 1));
        q.push_back(word(7, 0));
        q.push_back(word(7, 1));
        idle(5);
        @(negedge clk_a);
        for (int c = 0; c < 20; c++) begin
            take = !rd_flag;
            wr_en = 1'b1; wr_data = word(7, c + 2); rd_en = 1'b1;
            q.push_back(word(7, c + 2));
            @(negedge clk_a);
            if (take) begin
                e = q.pop_front();
                chk("R10 same-edge read", rd_data, e);
            end
        end
        wr_en = 1'b0; rd_en = 1'b0;
        while (q.size() > 0) begin
            e = q.pop_front();
            pop(d);
            chk("R10 drain after stream", d, e);
        end
        idle(5);
        chk("R10 empty at end", rd_flag, 1);
    endtask

    task automatic t_async(input bit mode);
        do_reset(mode, 1'b0, 0, 0, 1'b1);
        fork
            begin
                for (int i = 0; i < 40; i++) push(word(8, i));
            end
            begin
                logic [DW-1:0] d;
                for (int i = 0; i < 40; i++) begin
                    pop(d);
                    chk("R11 async order", d, word(8, i));
                end
            end
        join
        idle(10);
        chk("R11 async drained", rd_has(), 0);
        chk("R11 async write side free", wr_ok(), 1);
    endtask

    initial begin : main
        t_reset_state();
        t_std_order();
        t_empty_read();
        t_fwft();
        t_full_std();
        t_full_fwft();
        t_offsets();
        t_same_edge();
        t_async(1'b0);
        t_async(1'b1);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : watchdog
        repeat (150000) @(posedge clk_a);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule